// File: doc/BRIEF.md
# Negotiated-Width Burst Write Adapter

The adapter connects a local master that writes 64-bit words to a bus whose width is settled for each transaction. When the local master asks for a transaction, the adapter raises an active-low wide request toward the bus. In the cycle that follows, it samples the target's active-low wide acknowledge. That one sample fixes the width of the whole transaction.

If the target accepts the wide width, each local word reaches the bus unchanged in a single beat, and the adapter adds no cycles. If the target refuses, each local word is first captured into a holding register. It then leaves as two 32-bit beats on the low lanes: the lower half goes first, then the upper half, and each half carries its own four byte enables. While the halves are on the bus, the local master sees wait states. The unused upper lanes stay at zero. The local last flag marks the final word. The transaction ends once that word has fully left the adapter.

Top module: `burstWidthAdapter`

## Requirements
- R1: While reset is held and straight after it, busReq64N is 1, busValid is 0 and locAckN is 1.
- R2: If locReqN is 0 while the adapter is idle, busReq64N goes to 0 on the next cycle. It stays at 0 until the cycle after the final beat is accepted.
- R3: busAck64N is sampled in the first cycle in which busReq64N is 0. A value of 0 selects wide mode and a value of 1 selects narrow mode.
- R4: After that sampling cycle, changes on busAck64N have no effect on the transaction.
- R5: In wide mode, busValid equals locValid, and busData, busBe and busLast equal locData, locBe and locLast. locAckN is 0 exactly when locValid and busReady are both 1, so no wait state is added.
- R6: In narrow mode, a word is accepted (locAckN 0) only when the holding register is empty. The beats carry the value captured at that moment, even if locData changes afterwards. Each word is acknowledged exactly once.
- R7: In narrow mode, each word yields exactly two beats: first data bits 31:0 with enables 3:0, then bits 63:32 with enables 7:4. Both beats use bus lanes 31:0 and enable lanes 3:0.
- R8: In narrow mode, busData bits 63:32 and busBe bits 7:4 are 0 whenever busValid is 1.
- R9: In narrow mode, a beat that is offered but not accepted (busValid 1, busReady 0) is offered again with the same data and enables on the next cycle.
- R10: busLast marks the final beat: the last word in wide mode, or the upper half of the last word in narrow mode. busReq64N returns to 1 in the cycle after that beat is accepted.
- R11: locAckN is 0 only in cycles where locValid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| locReqN | input | 1 | Active-low transaction request from the local master |
| locValid | input | 1 | Local word present |
| locData | input | 64 | Local write word |
| locBe | input | 8 | Local byte enables |
| locLast | input | 1 | Local word is the final one |
| locAckN | output | 1 | Active-low local word accept; held high to insert wait states |
| busReq64N | output | 1 | Active-low wide request toward the target, held for the transaction |
| busAck64N | input | 1 | Active-low wide acknowledge from the target |
| busValid | output | 1 | Bus beat offered |
| busReady | input | 1 | Target can take the beat |
| busData | output | 64 | Bus data lanes |
| busBe | output | 8 | Bus byte enables |
| busLast | output | 1 | Final beat of the transaction |

## Verification
In wide mode, the bus outputs and locAckN depend on the inputs through logic alone. They are therefore checked in the same cycle as the stimulus, 2 ns after the falling edge on which the inputs change. In narrow mode, a word accepted in one cycle appears as its low beat one cycle later and as its high beat after the next accepted beat. The bench does not predict fixed cycle numbers here. It tracks beats through the busValid/busReady handshake and compares them in order against expected words computed arithmetically. busReq64N is checked one cycle after the request and one cycle after the final accepted beat.

// File: rtl/burstWidthPkg.sv
package burstWidthPkg;

  typedef enum logic [2:0] {
    IDLE_S,
    NEGO_S,
    PASS_S,
    FILL_S,
    LOW_S,
    HIGH_S
  } xferState_t;

  typedef struct packed {
    logic capture;
    logic selHigh;
    logic narrow;
  } dpStrobe_t;

endpackage

// File: rtl/widthCtrl.sv
module widthCtrl
  import burstWidthPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      locReqN,
  input  logic      locValid,
  input  logic      locLast,
  input  logic      busAck64N,
  input  logic      busReady,
  output logic      busReq64N,
  output logic      busValid,
  output logic      busLast,
  output logic      locAckN,
  output dpStrobe_t strb
);

  xferState_t state, nextState;
  logic       lastReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE_S;
      lastReg <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.capture) lastReg <= locLast;
    end
  end

  always_comb begin
    nextState    = state;
    busValid     = 1'b0;
    busLast      = 1'b0;
    locAckN      = 1'b1;
    strb         = '0;
    strb.narrow  = (state == FILL_S) || (state == LOW_S) || (state == HIGH_S);
    busReq64N    = (state == IDLE_S);
    unique case (state)
      IDLE_S: if (!locReqN) nextState = NEGO_S;
      NEGO_S: nextState = busAck64N ? FILL_S : PASS_S;
      PASS_S: begin
        busValid = locValid;
        busLast  = locLast;
        if (locValid && busReady) begin
          locAckN = 1'b0;
          if (locLast) nextState = IDLE_S;
        end
      end
      FILL_S: begin
        if (locValid) begin
          locAckN      = 1'b0;
          strb.capture = 1'b1;
          nextState    = LOW_S;
        end
      end
      LOW_S: begin
        busValid = 1'b1;
        if (busReady) nextState = HIGH_S;
      end
      HIGH_S: begin
        busValid     = 1'b1;
        strb.selHigh = 1'b1;
        busLast      = lastReg;
        if (busReady) nextState = lastReg ? IDLE_S : FILL_S;
      end
      default: nextState = IDLE_S;
    endcase
  end

  // R11
  ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !locAckN |-> locValid);

  // R10
  last_ends_txn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busReady && busLast) |=> busReq64N);

endmodule

// File: rtl/widthDatapath.sv
module widthDatapath
  import burstWidthPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [DATA_W-1:0]   locData,
  input  logic [DATA_W/8-1:0] locBe,
  output logic [DATA_W-1:0]   busData,
  output logic [DATA_W/8-1:0] busBe
);

  localparam int BE_W    = DATA_W / 8;
  localparam int HALF_W  = DATA_W / 2;
  localparam int HALF_BE = BE_W / 2;

  logic [DATA_W-1:0] holdData;
  logic [BE_W-1:0]   holdBe;
  logic [HALF_W-1:0] halfData;
  logic [HALF_BE-1:0] halfBe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdData <= '0;
      holdBe   <= '0;
    end else if (strb.capture) begin
      holdData <= locData;
      holdBe   <= locBe;
    end
  end

  always_comb begin
    halfData = strb.selHigh ? holdData[DATA_W-1:HALF_W] : holdData[HALF_W-1:0];
    halfBe   = strb.selHigh ? holdBe[BE_W-1:HALF_BE]    : holdBe[HALF_BE-1:0];
    if (strb.narrow) begin
      busData = {{HALF_W{1'b0}}, halfData};
      busBe   = {{HALF_BE{1'b0}}, halfBe};
    end else begin
      busData = locData;
      busBe   = locBe;
    end
  end

endmodule

// File: rtl/burstWidthAdapter.sv
module burstWidthAdapter
  import burstWidthPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                locReqN,
  input  logic                locValid,
  input  logic [DATA_W-1:0]   locData,
  input  logic [DATA_W/8-1:0] locBe,
  input  logic                locLast,
  output logic                locAckN,
  output logic                busReq64N,
  input  logic                busAck64N,
  output logic                busValid,
  input  logic                busReady,
  output logic [DATA_W-1:0]   busData,
  output logic [DATA_W/8-1:0] busBe,
  output logic                busLast
);

  localparam int BE_W    = DATA_W / 8;
  localparam int HALF_W  = DATA_W / 2;
  localparam int HALF_BE = BE_W / 2;

  dpStrobe_t strb;

  widthCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .locReqN   (locReqN),
    .locValid  (locValid),
    .locLast   (locLast),
    .busAck64N (busAck64N),
    .busReady  (busReady),
    .busReq64N (busReq64N),
    .busValid  (busValid),
    .busLast   (busLast),
    .locAckN   (locAckN),
    .strb      (strb)
  );

  widthDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .locData (locData),
    .locBe   (locBe),
    .busData (busData),
    .busBe   (busBe)
  );

  // R2
  req_raised_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq64N && !locReqN) |=> !busReq64N);

  // R8
  upper_lanes_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && strb.narrow) |->
      (busData[DATA_W-1:HALF_W] == '0 && busBe[BE_W-1:HALF_BE] == '0));

  // R9
  beat_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady && strb.narrow) |=>
      (busValid && $stable(busData) && $stable(busBe)));

endmodule

// File: tb/burstWidthAdapter_bench.sv
module burstWidthAdapter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        locReqN = 1'b1;
  logic        locValid = 1'b0;
  logic [63:0] locData = '0;
  logic [7:0]  locBe = '0;
  logic        locLast = 1'b0;
  logic        locAckN;
  logic        busReq64N;
  logic        busAck64N = 1'b1;
  logic        busValid;
  logic        busReady = 1'b0;
  logic [63:0] busData;
  logic [7:0]  busBe;
  logic        busLast;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  burstWidthAdapter u_burstWidthAdapter (
    .clk(clk), .rstN(rstN), .locReqN(locReqN), .locValid(locValid),
    .locData(locData), .locBe(locBe), .locLast(locLast), .locAckN(locAckN),
    .busReq64N(busReq64N), .busAck64N(busAck64N), .busValid(busValid),
    .busReady(busReady), .busData(busData), .busBe(busBe), .busLast(busLast)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] wordData(input int txn, input int k);
    logic [31:0] lo, hi;
    lo = 32'h5A00_0000 + 32'(txn * 256 + k * 2);
    hi = 32'hA500_0000 + 32'(txn * 256 + k * 2 + 1);
    return {hi, lo};
  endfunction

  function automatic logic [7:0] wordBe(input int txn, input int k);
    return 8'(txn * 29 + k * 13 + 5);
  endfunction

  task automatic runTxn(input int txn, input bit wide, input int len,
                        input int rmode, input bit gap);
    int wordIdx = 0;
    int beatIdx = 0;
    int cyc = 0;
    int acks = 0;
    int nBeats = wide ? len : 2 * len;
    bit done = 0;
    bit holdV = 0;
    bit pPend = 0;
    logic [63:0] pData = '0;
    logic [7:0]  pBe = '0;
    logic [63:0] expD, w;
    logic [7:0]  expB, wb;
    @(negedge clk);
    locReqN = 1'b0;
    busAck64N = 1'b1;
    #2;
    check(busReq64N == 1'b1, "R2 idle before request", 64'(busReq64N), 64'd1);
    @(negedge clk);
    locReqN = 1'b0 ^ 1'b1;
    busAck64N = wide ? 1'b0 : 1'b1;
    #2;
    check(busReq64N == 1'b0, "R2 request raised", 64'(busReq64N), 64'd0);
    check(busValid == 1'b0, "R3 no beat while negotiating", 64'(busValid), 64'd0);
    while (!done) begin
      @(negedge clk);
      cyc++;
      busAck64N = cyc[0];  // R4: toggled after negotiation
      busReady = (rmode == 0) ? 1'b1 : (rmode == 1) ? (cyc % 2 == 0) : (cyc % 3 == 0);
      locValid = (wordIdx < len) && (holdV || !gap || (cyc % 3 != 1));
      locData = locValid ? wordData(txn, wordIdx) : 64'hDEAD_BEEF_0BAD_F00D;
      locBe = locValid ? wordBe(txn, wordIdx) : 8'hC3;
      locLast = locValid && (wordIdx == len - 1);
      #2;
      if (!locAckN) check(locValid == 1'b1, "R11 ack without valid", 64'(locValid), 64'd1);
      check(busReq64N == 1'b0, "R2 request held", 64'(busReq64N), 64'd0);
      if (wide) begin
        check(busValid == locValid, "R5 valid passthrough", 64'(busValid), 64'(locValid));
        check(locAckN == !(locValid && busReady), "R5 no wait state",
              64'(locAckN), 64'(!(locValid && busReady)));
      end
      if (!wide && pPend) begin
        check(busValid && busData == pData && busBe == pBe, "R9 stalled beat held",
              busData, pData);
      end
      if (busValid && busReady) begin
        if (wide) begin
          expD = wordData(txn, beatIdx);
          expB = wordBe(txn, beatIdx);
        end else begin
          w = wordData(txn, beatIdx / 2);
          wb = wordBe(txn, beatIdx / 2);
          expD = (beatIdx % 2 == 1) ? {32'h0, w[63:32]} : {32'h0, w[31:0]};
          expB = (beatIdx % 2 == 1) ? {4'h0, wb[7:4]} : {4'h0, wb[3:0]};
          check(busData[63:32] == 32'h0 && busBe[7:4] == 4'h0, "R8 upper lanes zero",
                {busData[63:32], 24'h0, busBe}, 64'h0);
        end
        check(busData == expD, wide ? "R3 R5 wide beat data" : "R3 R6 R7 narrow beat data",
              busData, expD);
        check(busBe == expB, "R7 beat enables", 64'(busBe), 64'(expB));
        check(busLast == (beatIdx == nBeats - 1), "R10 last flag",
              64'(busLast), 64'(beatIdx == nBeats - 1));
        beatIdx++;
        if (beatIdx == nBeats) done = 1;
      end
      pPend = !wide && busValid && !busReady;
      pData = busData;
      pBe = busBe;
      if (locValid && !locAckN) begin
        wordIdx++;
        acks++;
        holdV = 0;
      end else begin
        holdV = locValid;
      end
      if (cyc > 300 && !done) begin
        check(1'b0, "R6 transaction stalled", 64'(beatIdx), 64'(nBeats));
        done = 1;
      end
    end
    @(negedge clk);
    locValid = 1'b0;
    locLast = 1'b0;
    busReady = 1'b0;
    #2;
    check(busReq64N == 1'b1, "R10 request released", 64'(busReq64N), 64'd1);
    check(busValid == 1'b0, "R10 idle after last", 64'(busValid), 64'd0);
    check(acks == len, "R6 one ack per word", 64'(acks), 64'(len));
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "R1 watchdog expired", 64'd0, 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int txn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    check(busReq64N == 1'b1 && busValid == 1'b0 && locAckN == 1'b1, "R1 reset state",
          {61'h0, busReq64N, busValid, locAckN}, 64'd5);
    rstN = 1'b1;
    @(negedge clk);
    #2;
    check(busReq64N == 1'b1 && busValid == 1'b0 && locAckN == 1'b1, "R1 after reset",
          {61'h0, busReq64N, busValid, locAckN}, 64'd5);
    for (int wideSel = 0; wideSel < 2; wideSel++) begin
      for (int len = 1; len <= 4; len++) begin
        for (int rmode = 0; rmode < 3; rmode++) begin
          for (int gap = 0; gap < 2; gap++) begin
            runTxn(txn, wideSel[0], len, rmode, gap[0]);
            txn++;
          end
        end
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule